// File: doc/BRIEF.md
# Static Receive Beam Combiner

This block turns one cell of a multi-channel radar data cube into a set of receive beams. A cell holds one complex sample for each receive channel, taken from the same range-Doppler position. For every beam the block multiplies each channel's sample by a fixed complex steering coefficient for that beam and channel. It adds the products over all channels, rounds the sum back to sample precision and emits the complex beam value. The emitted value carries the squared magnitude as a power figure for a detector further down the chain.

Steering coefficients sit in a register table with one entry for each beam and channel pair. A plain write port loads the table. Cells arrive over a valid/ready handshake. Beams leave, one at a time and tagged with their index, over a second valid/ready handshake. A cell is taken only when every beam of the previous cell has been delivered.

The sequencer has three states. `ST_IDLE` offers `in_ready`. Its transition *accept* (`in_valid` high) moves to `ST_CALC`. `ST_CALC` forms and registers one beam, then moves to `ST_EMIT` by the transition *compute*, which is unconditional. `ST_EMIT` holds `out_valid`. When `out_ready` is high there are two transitions out of it. *next-beam* returns to `ST_CALC` with the beam index incremented. *cell-done* returns to `ST_IDLE` after the highest beam.

Top module: `rx_beam_combiner`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `in_ready` is 1 and `out_valid` is 0. Reset clears every coefficient to zero, so a cell processed before any write gives re = im = power = 0 on every beam.
- R2: A write with `wr_en` high stores `wr_data` at entry `wr_addr = beam*NUM_CH + channel`. The real part is in `wr_data[31:16]` and the imaginary part in `wr_data[15:0]`, both signed Q1.15. The stored value is used by every beam computed after that clock edge.
- R3: Channel c's sample is `in_data[c*32 +: 32]`, with the real part in the upper 16 bits and the imaginary part in the lower 16 bits, both signed. A cell is captured on an edge where `in_valid` and `in_ready` are both high.
- R4: The beam sum is the exact complex sum over all channels of sample times coefficient, with no internal overflow for any input values.
- R5: Each part of the sum is rounded to output precision as floor((sum + 2^14) / 2^15).
- R6: A rounded part above 32767 is output as 32767, and a rounded part below -32768 is output as -32768.
- R7: `out_pow` equals out_re^2 + out_im^2 of the emitted, rounded values, as an unsigned 32-bit number.
- R8: Each accepted cell yields exactly NUM_BEAMS outputs, tagged `out_beam` = 0, 1, ... NUM_BEAMS-1, in that order.
- R9: `out_valid` first goes high two cycles after the accepting edge. After a handshake on any beam except the last, `out_valid` is low for one cycle and the next beam is valid in the cycle after that.
- R10: `in_ready` is low from the accepting edge until the handshake of the last beam, and it is high in the cycle right after that handshake. A cell offered while `in_ready` is low is not taken.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_beam`, `out_re`, `out_im` and `out_pow` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Coefficient write strobe |
| wr_addr | input | clog2(NUM_BEAMS*NUM_CH) | Coefficient entry, beam*NUM_CH + channel |
| wr_data | input | 32 | Coefficient, real in [31:16], imaginary in [15:0] |
| in_valid | input | 1 | Cell offered |
| in_ready | output | 1 | Block can take a cell |
| in_data | input | NUM_CH*32 | All channel samples of the cell |
| out_valid | output | 1 | Beam result present |
| out_ready | input | 1 | Downstream takes the beam result |
| out_beam | output | clog2(NUM_BEAMS) | Index of the beam on the output |
| out_re | output | 16 | Rounded, saturated real part |
| out_im | output | 16 | Rounded, saturated imaginary part |
| out_pow | output | 32 | Squared magnitude of out_re/out_im |

## Verification
Beam 0 of a cell is due two cycles after the accepting edge. Each later beam is due two cycles after the handshake of the beam before it, and `in_ready` is due again one cycle after the last handshake. The bench keeps a behavioural model that it advances at every rising edge from the inputs it drove for that edge. At the following falling edge it compares `in_ready`, `out_valid` and, when valid, all result fields against the model, so no result is checked a cycle early or late. Backpressure is applied with several `out_ready` patterns, and `in_valid` is held high with altered data while the block is busy, so both hold behaviour and refusal are seen at the ports.

// File: rtl/bf_pkg.sv
package bf_pkg;

    // sample and coefficient precision
    parameter int SAMP_W    = 16;
    parameter int COEF_FRAC = 15;
    parameter int CPLX_W    = 2 * SAMP_W;
    parameter int POW_W     = 2 * SAMP_W;

    typedef struct packed {
        logic signed [SAMP_W-1:0] re;
        logic signed [SAMP_W-1:0] im;
    } cplx_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_EMIT
    } bf_state_e;

endpackage

// File: rtl/bf_weight_bank.sv
module bf_weight_bank
    import bf_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_BEAMS = 8,
    parameter int AW        = $clog2(NUM_CH * NUM_BEAMS),
    parameter int BW        = (NUM_BEAMS > 1) ? $clog2(NUM_BEAMS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  cplx_t                 wr_data,
    input  logic [BW-1:0]         rd_beam,
    output cplx_t [NUM_CH-1:0]    rd_coef
);

    localparam int ENTRIES = NUM_CH * NUM_BEAMS;

    cplx_t coef_q [ENTRIES];

    // entry layout: beam-major, channel-minor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                coef_q[e] <= '0;
            end
        end else if (wr_en) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (wr_addr == AW'(e)) begin
                    coef_q[e] <= wr_data;
                end
            end
        end
    end

    // one read lane per channel for the selected beam
    for (genvar c = 0; c < NUM_CH; c++) begin : g_rd
        assign rd_coef[c] = coef_q[AW'(NUM_CH * int'(rd_beam) + c)];
    end

endmodule

// File: rtl/bf_cmac_sum.sv
module bf_cmac_sum
    import bf_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ACC_W  = 2 * SAMP_W + 2 + $clog2(NUM_CH)
) (
    input  cplx_t [NUM_CH-1:0]       samp,
    input  cplx_t [NUM_CH-1:0]       coef,
    output logic signed [ACC_W-1:0]  sum_re,
    output logic signed [ACC_W-1:0]  sum_im
);

    localparam int PROD_W = 2 * SAMP_W;

    logic signed [ACC_W-1:0] term_re [NUM_CH];
    logic signed [ACC_W-1:0] term_im [NUM_CH];

    // one complex multiplier per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        logic signed [PROD_W-1:0] p_rr;
        logic signed [PROD_W-1:0] p_ii;
        logic signed [PROD_W-1:0] p_ri;
        logic signed [PROD_W-1:0] p_ir;

        assign p_rr = samp[c].re * coef[c].re;
        assign p_ii = samp[c].im * coef[c].im;
        assign p_ri = samp[c].re * coef[c].im;
        assign p_ir = samp[c].im * coef[c].re;

        assign term_re[c] = ACC_W'(p_rr) - ACC_W'(p_ii);
        assign term_im[c] = ACC_W'(p_ri) + ACC_W'(p_ir);
    end

    // channel sum
    always_comb begin
        sum_re = '0;
        sum_im = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            sum_re = sum_re + term_re[c];
            sum_im = sum_im + term_im[c];
        end
    end

endmodule

// File: rtl/bf_round_power.sv
module bf_round_power
    import bf_pkg::*;
#(
    parameter int ACC_W = 36
) (
    input  logic signed [ACC_W-1:0] acc_re,
    input  logic signed [ACC_W-1:0] acc_im,
    output cplx_t                   res,
    output logic [POW_W-1:0]        power
);

    localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(1) <<< (COEF_FRAC - 1);
    localparam logic signed [ACC_W-1:0] TOP_V  = ACC_W'((1 << (SAMP_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] BOT_V  = ~TOP_V;

    function automatic logic signed [SAMP_W-1:0] round_sat(
        input logic signed [ACC_W-1:0] v
    );
        logic signed [ACC_W-1:0] biased;
        logic signed [ACC_W-1:0] scaled;
        biased = v + HALF;
        scaled = biased >>> COEF_FRAC;
        if (scaled > TOP_V) begin
            return TOP_V[SAMP_W-1:0];
        end else if (scaled < BOT_V) begin
            return BOT_V[SAMP_W-1:0];
        end
        return scaled[SAMP_W-1:0];
    endfunction

    logic signed [2*SAMP_W-1:0] sq_re;
    logic signed [2*SAMP_W-1:0] sq_im;

    always_comb begin
        res.re = round_sat(acc_re);
        res.im = round_sat(acc_im);
    end

    assign sq_re = res.re * res.re;
    assign sq_im = res.im * res.im;
    assign power = POW_W'($unsigned(sq_re)) + POW_W'($unsigned(sq_im));

endmodule

// File: rtl/rx_beam_combiner.sv
module rx_beam_combiner
    import bf_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_BEAMS = 8,
    parameter int AW        = $clog2(NUM_CH * NUM_BEAMS),
    parameter int BW        = (NUM_BEAMS > 1) ? $clog2(NUM_BEAMS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [CPLX_W-1:0]        wr_data,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [NUM_CH*CPLX_W-1:0] in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [BW-1:0]            out_beam,
    output logic [SAMP_W-1:0]        out_re,
    output logic [SAMP_W-1:0]        out_im,
    output logic [POW_W-1:0]         out_pow
);

    localparam int ACC_W = 2 * SAMP_W + 2 + $clog2(NUM_CH);
    localparam logic [BW-1:0] LAST_BEAM = BW'(NUM_BEAMS - 1);

    bf_state_e state_q;
    bf_state_e state_d;

    cplx_t [NUM_CH-1:0] cell_q;
    cplx_t [NUM_CH-1:0] coef_sel;
    logic  [BW-1:0]     beam_q;
    logic               last_beam;
    logic               take_cell;
    logic               give_beam;

    logic signed [ACC_W-1:0] sum_re;
    logic signed [ACC_W-1:0] sum_im;
    cplx_t                   beam_val;
    logic [POW_W-1:0]        beam_pow;

    cplx_t            res_q;
    logic [POW_W-1:0] pow_q;

    // coefficient table
    bf_weight_bank #(
        .NUM_CH    (NUM_CH),
        .NUM_BEAMS (NUM_BEAMS),
        .AW        (AW),
        .BW        (BW)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (cplx_t'(wr_data)),
        .rd_beam (beam_q),
        .rd_coef (coef_sel)
    );

    // weighted channel sum
    bf_cmac_sum #(
        .NUM_CH (NUM_CH),
        .ACC_W  (ACC_W)
    ) u_mac (
        .samp   (cell_q),
        .coef   (coef_sel),
        .sum_re (sum_re),
        .sum_im (sum_im)
    );

    // output precision and power
    bf_round_power #(
        .ACC_W (ACC_W)
    ) u_rnd (
        .acc_re (sum_re),
        .acc_im (sum_im),
        .res    (beam_val),
        .power  (beam_pow)
    );

    assign last_beam = (beam_q == LAST_BEAM);
    assign take_cell = in_valid && (state_q == ST_IDLE);
    assign give_beam = out_ready && (state_q == ST_EMIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: accept, compute, next-beam, cell-done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d = ST_CALC;
                end
            end
            ST_CALC: begin
                state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (out_ready) begin
                    state_d = last_beam ? ST_IDLE : ST_CALC;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_EMIT);
        out_beam  = beam_q;
        out_re    = res_q.re;
        out_im    = res_q.im;
        out_pow   = pow_q;
    end

    // cell capture and beam index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
            beam_q <= '0;
        end else if (take_cell) begin
            cell_q <= cplx_t [NUM_CH-1:0]'(in_data);
            beam_q <= '0;
        end else if (give_beam && !last_beam) begin
            beam_q <= beam_q + 1'b1;
        end
    end

    // result register, loaded in ST_CALC
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            pow_q <= '0;
        end else if (state_q == ST_CALC) begin
            res_q <= beam_val;
            pow_q <= beam_pow;
        end
    end

    // ---------------- assertions ----------------

    // R10: taking a cell and presenting a beam never overlap
    p_ready_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R11: a stalled beam holds its value
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_beam) &&
            $stable(out_re) && $stable(out_im) && $stable(out_pow)));

    // R9: first beam of a cell two cycles after acceptance
    p_first_beam_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && !out_valid)
            ##1 (out_valid && out_beam == '0));

    // R8: beams follow in ascending order with one idle cycle between
    p_beam_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_beam != LAST_BEAM) |=> !out_valid
            ##1 (out_valid && out_beam == BW'($past(out_beam, 2) + 1'b1)));

    // R10: the last handshake frees the input
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_beam == LAST_BEAM) |=> in_ready);

endmodule

// File: tb/test_rx_beam_combiner.sv
module test_rx_beam_combiner;

    localparam int NCH = 4;
    localparam int NB  = 8;
    localparam int AW  = $clog2(NCH * NB);
    localparam int BW  = $clog2(NB);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  wr_en = 1'b0;
    logic [AW-1:0]         wr_addr = '0;
    logic [31:0]           wr_data = '0;
    logic                  in_valid = 1'b0;
    logic                  in_ready;
    logic [NCH*32-1:0]     in_data = '0;
    logic                  out_valid;
    logic                  out_ready = 1'b0;
    logic [BW-1:0]         out_beam;
    logic [15:0]           out_re;
    logic [15:0]           out_im;
    logic [31:0]           out_pow;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    rx_beam_combiner #(.NUM_CH(NCH), .NUM_BEAMS(NB)) i_rx_beam_combiner (
        .clk (clk), .rst_n (rst_n),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
        .out_valid (out_valid), .out_ready (out_ready), .out_beam (out_beam),
        .out_re (out_re), .out_im (out_im), .out_pow (out_pow)
    );

    // ---------------- reference model ----------------
    int     w_re [NCH*NB];
    int     w_im [NCH*NB];
    int     c_re [NCH];
    int     c_im [NCH];
    int     m_phase = 0;          // 0 idle, 1 computing, 2 presenting
    int     m_beam  = 0;
    longint m_re, m_im, m_pow;
    bit     stall_prev = 0;
    logic [BW-1:0] h_beam;
    logic [15:0]   h_re, h_im;
    logic [31:0]   h_pow;
    int     cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic longint rnd_sat(longint v);
        longint r;
        r = (v + 16384) >>> 15;           // R5
        if (r > 32767)  r = 32767;        // R6
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic model_beam(int b);
        longint ar = 0;
        longint ai = 0;
        for (int c = 0; c < NCH; c++) begin
            ar += longint'(c_re[c]) * w_re[b*NCH+c] - longint'(c_im[c]) * w_im[b*NCH+c];
            ai += longint'(c_re[c]) * w_im[b*NCH+c] + longint'(c_im[c]) * w_re[b*NCH+c];
        end
        m_re  = rnd_sat(ar);
        m_im  = rnd_sat(ai);
        m_pow = m_re * m_re + m_im * m_im;   // R7
    endtask

    task automatic check(bit ok, string req, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // one clock: advance model at the rising edge, compare at the falling edge
    task automatic tick();
        logic [NCH*32-1:0] seen;
        @(posedge clk);
        cyc++;
        stall_prev = out_valid && !out_ready;
        h_beam = out_beam; h_re = out_re; h_im = out_im; h_pow = out_pow;
        seen = in_data;
        case (m_phase)
            0: if (in_valid) begin          // R3 packing
                for (int c = 0; c < NCH; c++) begin
                    c_re[c] = int'($signed(seen[c*32+16 +: 16]));
                    c_im[c] = int'($signed(seen[c*32 +: 16]));
                end
                m_beam  = 0;
                m_phase = 1;
            end
            1: begin
                model_beam(m_beam);
                m_phase = 2;
            end
            default: if (out_ready) begin
                if (m_beam == NB - 1) m_phase = 0;
                else begin m_beam++; m_phase = 1; end
            end
        endcase
        if (wr_en) begin                     // R2 layout
            w_re[wr_addr] = int'($signed(wr_data[31:16]));
            w_im[wr_addr] = int'($signed(wr_data[15:0]));
        end
        @(negedge clk);
        check(in_ready == (m_phase == 0), "R10 in_ready", longint'(in_ready), longint'(m_phase == 0));
        check(out_valid == (m_phase == 2), "R9 out_valid", longint'(out_valid), longint'(m_phase == 2));
        if (m_phase == 2 && out_valid) begin
            check(int'(out_beam) == m_beam, "R8 beam tag", longint'(out_beam), m_beam);
            check(longint'($signed(out_re)) == m_re, "R4/R5/R6 re", longint'($signed(out_re)), m_re);
            check(longint'($signed(out_im)) == m_im, "R4/R5/R6 im", longint'($signed(out_im)), m_im);
            check({32'd0, out_pow} == m_pow, "R7 power", longint'(out_pow), m_pow);
        end
        if (stall_prev) begin
            check(out_valid && out_beam == h_beam && out_re == h_re && out_im == h_im
                  && out_pow == h_pow, "R11 hold", longint'(out_re), longint'(h_re));
        end
    endtask

    task automatic write_coef(int b, int c, int re, int im);
        wr_en   = 1'b1;
        wr_addr = AW'(b * NCH + c);
        wr_data = {16'(re), 16'(im)};
        tick();
        wr_en   = 1'b0;
    endtask

    function automatic logic ready_bit(int mode);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (mode)
            0:       return 1'b1;
            1:       return lfsr[0];
            default: return (cyc % 3) == 0;
        endcase
    endfunction

    // offer a cell; keep in_valid high with altered data while busy (R10)
    task automatic run_cell(int s_re[NCH], int s_im[NCH], int mode);
        bit taken = 0;
        for (int c = 0; c < NCH; c++) in_data[c*32 +: 32] = {16'(s_re[c]), 16'(s_im[c])};
        in_valid = 1'b1;
        while (1) begin
            out_ready = ready_bit(mode);
            tick();
            if (!taken && m_phase != 0) begin
                taken = 1;
                in_data = ~in_data;
            end else if (taken && m_phase == 0) begin
                break;
            end
        end
        in_valid  = 1'b0;
        out_ready = 1'b0;
    endtask

    function automatic int hash16(int i);
        return int'($signed(16'((i * 40503 + 1723) ^ (i << 7))));
    endfunction

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int a_re[NCH]; int a_im[NCH];
        for (int e = 0; e < NCH*NB; e++) begin w_re[e] = 0; w_im[e] = 0; end

        // R1: reset state
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset outputs",
              longint'({in_ready, out_valid}), 2);
        rst_n = 1'b1;
        tick();

        // R1: coefficients cleared by reset -> all-zero beams
        for (int c = 0; c < NCH; c++) begin a_re[c] = 1000*(c+1); a_im[c] = -700*c; end
        run_cell(a_re, a_im, 0);

        // R2/R3: beam b picks channel b%NCH at unity gain
        for (int b = 0; b < NB; b++)
            for (int c = 0; c < NCH; c++)
                write_coef(b, c, (c == b % NCH) ? 32767 : 0, 0);
        run_cell(a_re, a_im, 0);

        // R4: general coefficients, two cells, backpressure patterns (R11)
        for (int b = 0; b < NB; b++)
            for (int c = 0; c < NCH; c++)
                write_coef(b, c, hash16(b*NCH+c), hash16(b*NCH+c+97));
        for (int c = 0; c < NCH; c++) begin a_re[c] = hash16(c+300); a_im[c] = hash16(c+500); end
        run_cell(a_re, a_im, 1);
        for (int c = 0; c < NCH; c++) begin a_re[c] = hash16(c+11); a_im[c] = -hash16(c+41); end
        run_cell(a_re, a_im, 2);

        // R6: positive and negative saturation
        for (int b = 0; b < NB; b++)
            for (int c = 0; c < NCH; c++)
                write_coef(b, c, 32767, (b % 2 == 1) ? 32767 : 0);
        for (int c = 0; c < NCH; c++) begin a_re[c] = 32767; a_im[c] = 0; end
        run_cell(a_re, a_im, 0);
        for (int c = 0; c < NCH; c++) begin a_re[c] = -32768; a_im[c] = -32768; end
        run_cell(a_re, a_im, 1);

        // R5: rounding at the half-way point
        for (int b = 0; b < NB; b++)
            for (int c = 0; c < NCH; c++)
                write_coef(b, c, (c == 0) ? 16384 : 0, (b == 3 && c == 0) ? -16384 : 0);
        a_re = '{1, 0, 0, 0}; a_im = '{3, 0, 0, 0};
        run_cell(a_re, a_im, 0);
        a_re = '{-1, 0, 0, 0}; a_im = '{-3, 0, 0, 0};
        run_cell(a_re, a_im, 2);

        repeat (4) tick();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule